// File: doc/BRIEF.md
# Keyboard and Display Register Block

This block sits on a 16-bit word-addressed memory bus and gives software four registers: keyboard status, keyboard data, display status and display data. A keyboard source hands in characters one at a time with a strobe. A display sink receives characters through an outgoing strobe and answers with a done pulse when it has finished with each one.

Each direction has a ready flag that holds one character. A keystroke that arrives while the previous one is still unread is discarded. A write to the display data register while the display is busy is also discarded. Each status register has a software-writable enable bit. When that enable bit and the ready flag are both set, the block raises the interrupt request line for that device.

Read data is combinational from the address and the read strobe. Side effects such as clearing a ready flag take place at the clock edge that ends the bus cycle.

Top module: `kbd_disp_regs`

## Requirements
- R1: The address map is fixed: keyboard status at 0xFE00, keyboard data at 0xFE02, display status at 0xFE04 and display data at 0xFE06. A read of any other address returns 0, and an access to any other address changes no state.
- R2: When a keystroke strobe arrives while the keyboard ready flag is 0, the ready flag reads 1 (keyboard status bit 15) from the next cycle. The keyboard data register then returns the character in bits [7:0], and bits [15:8] always read 0.
- R3: While the keyboard ready flag is 1, incoming keystrokes are dropped, and the keyboard data register keeps the character it holds.
- R4: A bus read of the keyboard data register clears the keyboard ready flag from the next cycle, so the next keystroke is captured again.
- R5: When a keystroke arrives in the same cycle as a read of the keyboard data register, the read returns the old character. The new keystroke is captured, and the ready flag stays 1.
- R6: A write to the display data register while display ready (display status bit 15) is 1 produces a one-cycle display strobe in the next cycle, carrying write data bits [7:0]. Display ready reads 0 from that cycle.
- R7: A write to the display data register while display ready is 0 produces no strobe and does not change the character sent.
- R8: Display ready returns to 1 in the cycle after the display sink pulses done.
- R9: Status bit 14 is a writable interrupt enable. Writes to status bit 15 are ignored, and status bits [13:0] read 0.
- R10: Each device's interrupt request is high exactly when its status bits 15 and 14 are both 1.
- R11: After reset, keyboard ready is 0, display ready is 1, both enables are 0 and no strobe or interrupt is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Word address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of bus_rd |
| key_valid | input | 1 | Keystroke strobe from the keyboard source |
| key_char | input | 8 | Character code of the keystroke |
| disp_valid | output | 1 | One-cycle strobe to the display sink |
| disp_char | output | 8 | Character offered to the display sink |
| disp_done | input | 1 | Display sink has finished the last character |
| kbd_irq | output | 1 | Keyboard interrupt request |
| disp_irq | output | 1 | Display interrupt request |

## Verification
Two events can fall in the same cycle: a keystroke that sets the keyboard ready flag, and a bus read of the keyboard data register that clears it. The bench first leaves a character unread. It then raises the keystroke strobe and the data-register read in the same cycle. It checks that the read returns the old character, and that a later status read still shows ready. A second data read must then return the new character. On the display side, the bench holds off done so that a write lands while the display is busy, and it checks that no strobe comes out.

// File: rtl/kbd_disp_regs.sv
module kbd_disp_regs #(
  parameter int          AW        = 16,
  parameter int          DW        = 16,
  parameter int          CW        = 8,
  parameter logic [15:0] KSTAT_A   = 16'hFE00,
  parameter logic [15:0] KDATA_A   = 16'hFE02,
  parameter logic [15:0] DSTAT_A   = 16'hFE04,
  parameter logic [15:0] DDATA_A   = 16'hFE06
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          key_valid,
  input  logic [CW-1:0] key_char,
  output logic          disp_valid,
  output logic [CW-1:0] disp_char,
  input  logic          disp_done,
  output logic          kbd_irq,
  output logic          disp_irq
);
  localparam int RDY = DW - 1;
  localparam int IEN = DW - 2;

  logic          kbd_rdy, kbd_ie, dsp_rdy, dsp_ie;
  logic [CW-1:0] kbd_char;

  logic sel_ks, sel_kd, sel_ds, sel_dd;
  assign sel_ks = bus_addr == AW'(KSTAT_A);
  assign sel_kd = bus_addr == AW'(KDATA_A);
  assign sel_ds = bus_addr == AW'(DSTAT_A);
  assign sel_dd = bus_addr == AW'(DDATA_A);

  logic kbd_take, kbd_load, dsp_send;
  assign kbd_take = bus_rd && sel_kd;
  assign kbd_load = key_valid && (!kbd_rdy || kbd_take);
  assign dsp_send = bus_wr && sel_dd && dsp_rdy;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel_ks) begin
        bus_rdata[RDY] = kbd_rdy;
        bus_rdata[IEN] = kbd_ie;
      end else if (sel_kd) begin
        bus_rdata[CW-1:0] = kbd_char;
      end else if (sel_ds) begin
        bus_rdata[RDY] = dsp_rdy;
        bus_rdata[IEN] = dsp_ie;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kbd_rdy  <= 1'b0;
      kbd_ie   <= 1'b0;
      kbd_char <= '0;
    end else begin
      if (bus_wr && sel_ks) kbd_ie <= bus_wdata[IEN];
      if (kbd_load) begin
        kbd_rdy  <= 1'b1;
        kbd_char <= key_char;
      end else if (kbd_take) begin
        kbd_rdy  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dsp_rdy    <= 1'b1;
      dsp_ie     <= 1'b0;
      disp_valid <= 1'b0;
      disp_char  <= '0;
    end else begin
      disp_valid <= dsp_send;
      if (bus_wr && sel_ds) dsp_ie <= bus_wdata[IEN];
      if (dsp_send) begin
        dsp_rdy   <= 1'b0;
        disp_char <= bus_wdata[CW-1:0];
      end else if (disp_done) begin
        dsp_rdy   <= 1'b1;
      end
    end
  end

  assign kbd_irq  = kbd_rdy && kbd_ie;
  assign disp_irq = dsp_rdy && dsp_ie;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !sel_ks && !sel_kd && !sel_ds && !sel_dd) |-> bus_rdata == '0); // R1
  AST_KBD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && !kbd_rdy) |=> (kbd_rdy && kbd_char == $past(key_char))); // R2
  AST_KBD_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_rdy && !kbd_take) |=> $stable(kbd_char)); // R3
  AST_KBD_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_take && !key_valid) |=> !kbd_rdy); // R4
  AST_DISP_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> !disp_valid); // R6
  AST_DISP_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!dsp_rdy && bus_wr && sel_dd) |=> (!disp_valid && $stable(disp_char))); // R7
  AST_DISP_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!dsp_rdy && disp_done) |=> dsp_rdy); // R8
endmodule

// File: tb/kbd_disp_regs_test.sv
module kbd_disp_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] bus_addr = 0;
  logic        bus_rd = 0, bus_wr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        key_valid = 0;
  logic [7:0]  key_char = 0;
  logic        disp_valid;
  logic [7:0]  disp_char;
  logic        disp_done = 0;
  logic        kbd_irq, disp_irq;

  int checks = 0, fails = 0;
  bit finished = 0;

  kbd_disp_regs uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic key(logic [7:0] c);
    @(negedge clk);
    key_valid = 1; key_char = c;
    @(negedge clk);
    key_valid = 0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    disp_done = 1;
    @(negedge clk);
    disp_done = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(16'hFE00, d); check("R11 kbd status", d, 16'h0000);
    rd(16'hFE04, d); check("R11 disp status", d, 16'h8000);
    check("R11 strobes/irqs", {disp_valid, kbd_irq, disp_irq}, 3'b000);
  endtask

  task automatic t_keyboard();
    logic [15:0] d;
    key(8'h41);
    rd(16'hFE00, d); check("R2 ready set", d, 16'h8000);
    key(8'h42);
    rd(16'hFE02, d); check("R3 first char kept, R2 high byte zero", d, 16'h0041);
    rd(16'hFE00, d); check("R4 ready cleared", d, 16'h0000);
    key(8'h43);
    rd(16'hFE02, d); check("R4 capture re-enabled", d, 16'h0043);
  endtask

  task automatic t_collision();
    logic [15:0] d;
    key(8'h61);
    @(negedge clk);
    key_valid = 1; key_char = 8'h62; bus_addr = 16'hFE02; bus_rd = 1;
    #1 d = bus_rdata;
    @(negedge clk);
    key_valid = 0; bus_rd = 0;
    check("R5 old char returned", d, 16'h0061);
    rd(16'hFE00, d); check("R5 ready stays", d[15], 1'b1);
    rd(16'hFE02, d); check("R5 new char captured", d, 16'h0062);
  endtask

  task automatic t_display();
    logic [15:0] d;
    wr(16'hFE06, 16'hAB5A);
    check("R6 strobe", disp_valid, 1'b1);
    check("R6 char", disp_char, 8'h5A);
    @(negedge clk);
    check("R6 one cycle", disp_valid, 1'b0);
    rd(16'hFE04, d); check("R6 busy", d, 16'h0000);
    wr(16'hFE06, 16'h0033);
    check("R7 no strobe", disp_valid, 1'b0);
    check("R7 char unchanged", disp_char, 8'h5A);
    done_pulse();
    rd(16'hFE04, d); check("R8 ready back", d, 16'h8000);
    wr(16'hFE06, 16'h0034);
    check("R8 accepts again", {disp_valid, disp_char}, {1'b1, 8'h34});
    done_pulse();
  endtask

  task automatic t_status_irq();
    logic [15:0] d;
    wr(16'hFE00, 16'hFFFF);
    rd(16'hFE00, d); check("R9 ie set, bit15 write ignored", d, 16'h4000);
    check("R10 kbd irq low while not ready", kbd_irq, 1'b0);
    key(8'h55);
    check("R10 kbd irq", kbd_irq, 1'b1);
    rd(16'hFE02, d);
    check("R10 kbd irq drops", kbd_irq, 1'b0);
    wr(16'hFE04, 16'h4000);
    check("R10 disp irq", disp_irq, 1'b1);
    wr(16'hFE06, 16'h0011);
    check("R10 disp irq busy", disp_irq, 1'b0);
    done_pulse();
    check("R10 disp irq back", disp_irq, 1'b1);
    wr(16'hFE04, 16'h0000);
    wr(16'hFE00, 16'h0000);
    rd(16'hFE04, d); check("R9 ie cleared", d, 16'h8000);
  endtask

  task automatic t_unmapped();
    logic [15:0] d;
    key(8'h77);
    rd(16'hFE01, d); check("R1 unmapped read zero", d, 16'h0000);
    rd(16'hFE08, d); check("R1 unmapped read zero", d, 16'h0000);
    rd(16'hFE00, d); check("R1 no side effect on kbd ready", d, 16'h8000);
    wr(16'hFE07, 16'h0099);
    check("R1 unmapped write no strobe", disp_valid, 1'b0);
    wr(16'hFE05, 16'h4000);
    rd(16'hFE04, d); check("R1 unmapped write no state", d, 16'h8000);
    rd(16'hFE02, d); check("R1 char intact", d, 16'h0077);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_keyboard();
    t_collision();
    t_display();
    t_status_irq();
    t_unmapped();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end
endmodule